// File: doc/BRIEF.md
# Accumulator Execute and Branch Unit

This unit performs the integer and control-flow work of a single-accumulator processor. It owns the accumulator and the program counter. Each operation arrives with a resolved operand and an index-register number. The resolved operand is either a data value or a jump target, and an earlier stage has already worked out the addressing. The unit has no condition flags. Each conditional jump looks at the live accumulator when it executes: one tests the sign bit, the other tests for zero.

Operations enter through a valid/ready handshake. The upstream stage must hold `in_valid`, `in_op`, `in_operand` and `in_xreg` steady until a rising edge at which `in_ready` is also high. `in_ready` falls while a multiply or divide is being worked out, and it stays low for good once a halt has executed.

Stores and index-register writes leave the unit as one-cycle pulses. These pulses take no back-pressure, so the memory or register-file stage must accept them in that cycle. `done` pulses once per operation, in the first cycle in which all of its results are visible.

Top module: `exe_acc_unit`

## Requirements
- R1: After reset the accumulator and program counter read 0, `halted`, `done`, `st_valid`, `xw_en` and `div_err` are low, and `in_ready` is high.
- R2: An operation is taken at a rising edge where `in_valid` and `in_ready` are both high. The opcode values are: load 0, store 1, index load 2, add 3, subtract 4, multiply 5, divide 6, negate 7, shift left 8, shift right 9, jump-if-negative 10, jump 11, jump-if-zero 12, halt 13, and 14 and 15 are no-ops. Single-cycle operations raise `done` in the cycle right after acceptance. Multiply and divide hold `in_ready` low until their `done`.
- R3: Load puts the operand into the accumulator. Add and subtract wrap modulo 2^32. Negate gives the two's complement of the accumulator and ignores the operand.
- R4: Multiply keeps the low 32 bits of the product of the two integers.
- R5: Divide gives the signed quotient truncated toward zero. The most negative value divided by -1 gives the most negative value.
- R6: Divide by zero leaves the accumulator unchanged and raises `div_err` together with `done`.
- R7: Both shifts move the accumulator by the low 5 bits of the operand and fill the vacated bits with zeros.
- R8: Store pulses `st_valid` for one cycle with `st_data` equal to the accumulator, and it leaves the accumulator unchanged.
- R9: Index load pulses `xw_en` for one cycle with `xw_sel` equal to `in_xreg` and `xw_data` equal to the operand, and it leaves the accumulator unchanged.
- R10: Jump-if-negative is taken exactly when accumulator bit 31 is set. Jump-if-zero is taken exactly when the accumulator is 0. A taken jump loads the operand into the program counter, and one not taken adds one to it.
- R11: The unconditional jump always loads the operand into the program counter.
- R12: Every operation other than a jump or halt adds one to the program counter.
- R13: Halt raises `halted`, keeps `in_ready` low, ignores its operand and all later requests, and freezes the accumulator and program counter until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request valid |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 4 | Operation code |
| in_operand | input | 32 | Resolved data value or jump target |
| in_xreg | input | 4 | Index register number for index load |
| acc_o | output | 32 | Accumulator value |
| pc_o | output | 32 | Program counter |
| st_valid | output | 1 | Store pulse |
| st_data | output | 32 | Data to store |
| xw_en | output | 1 | Index register write pulse |
| xw_sel | output | 4 | Index register number |
| xw_data | output | 32 | Index register value |
| halted | output | 1 | Machine stopped |
| done | output | 1 | Operation complete pulse |
| div_err | output | 1 | Divide by zero pulse |

## Verification
Add, subtract, multiply and divide are swept over every pair drawn from a set of edge values: zero, plus and minus one, small odd numbers, the largest positive value, the most negative value and a mixed bit pattern. These pairs separate wraparound errors from sign-handling errors and truncation-direction errors, and they catch a wrong result for the most negative value divided by -1. Shifts are tried at all 32 amounts with the operand's upper bits set, which shows whether only the low 5 bits are used and whether the fill is zero. Both conditional jumps are run against negative, zero, positive and most negative accumulators. After that, a long random sequence of operations is compared against a model for the accumulator and program counter.

// File: rtl/exe_pkg.sv
package exe_pkg;
  typedef enum logic [3:0] {
    OP_LDA  = 4'd0,
    OP_STA  = 4'd1,
    OP_LDX  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_MUL  = 4'd5,
    OP_DIV  = 4'd6,
    OP_NEG  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_JNEG = 4'd10,
    OP_JMP  = 4'd11,
    OP_JZ   = 4'd12,
    OP_HALT = 4'd13,
    OP_NOP1 = 4'd14,
    OP_NOP2 = 4'd15
  } op_e;
endpackage

// File: rtl/exe_alu.sv
module exe_alu import exe_pkg::*; #(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res,
  output logic         wr
);
  localparam int SHW = $clog2(W);

  always_comb begin
    res = acc;
    wr  = 1'b1;
    case (op)
      OP_LDA:  res = opnd;
      OP_ADD:  res = acc + opnd;
      OP_SUB:  res = acc - opnd;
      OP_NEG:  res = -acc;
      OP_SHL:  res = acc << opnd[SHW-1:0];
      OP_SHR:  res = acc >> opnd[SHW-1:0];
      default: wr  = 1'b0;
    endcase
  end
endmodule

// File: rtl/exe_branch.sv
module exe_branch import exe_pkg::*; #(
  parameter int W  = 32,
  parameter int PW = 32
) (
  input  op_e           op,
  input  logic [W-1:0]  acc,
  input  logic [PW-1:0] pc,
  input  logic [PW-1:0] target,
  output logic [PW-1:0] next_pc
);
  logic taken;

  always_comb begin
    case (op)
      OP_JNEG: taken = acc[W-1];
      OP_JZ:   taken = (acc == '0);
      OP_JMP:  taken = 1'b1;
      default: taken = 1'b0;
    endcase
    if (op == OP_HALT)
      next_pc = pc;
    else if (taken)
      next_pc = target;
    else
      next_pc = pc + PW'(1);
  end
endmodule

// File: rtl/exe_muldiv.sv
module exe_muldiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_div,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         fin,
  output logic         dz,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W);

  logic          active, mode_div, neg_q, fin_q, dz_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  p, x, y, rem, hold_a;
  logic [W:0]    rem_sh, rem_sub;
  logic [W-1:0]  mag_a, mag_b;

  assign mag_a   = a[W-1] ? -a : a;
  assign mag_b   = b[W-1] ? -b : b;
  assign rem_sh  = {rem, p[W-1]};
  assign rem_sub = rem_sh - {1'b0, x};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; mode_div <= 1'b0; neg_q <= 1'b0;
      fin_q <= 1'b0; dz_q <= 1'b0; cnt <= '0;
      p <= '0; x <= '0; y <= '0; rem <= '0; hold_a <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        mode_div <= is_div;
        hold_a   <= a;
        cnt      <= '0;
        rem      <= '0;
        dz_q     <= is_div && (b == '0);
        if (is_div && (b == '0)) begin
          fin_q  <= 1'b1;
        end else begin
          active <= 1'b1;
          if (is_div) begin
            p     <= mag_a;
            x     <= mag_b;
            neg_q <= a[W-1] ^ b[W-1];
          end else begin
            p     <= '0;
            x     <= a;
            y     <= b;
            neg_q <= 1'b0;
          end
        end
      end else if (active) begin
        if (mode_div) begin
          if (!rem_sub[W]) begin
            rem <= rem_sub[W-1:0];
            p   <= {p[W-2:0], 1'b1};
          end else begin
            rem <= rem_sh[W-1:0];
            p   <= {p[W-2:0], 1'b0};
          end
        end else begin
          if (y[0]) p <= p + x;
          x <= x << 1;
          y <= y >> 1;
        end
        cnt <= cnt + CW'(1);
        if (cnt == CW'(W-1)) begin
          active <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign fin    = fin_q;
  assign dz     = dz_q;
  assign result = dz_q ? hold_a : (neg_q ? -p : p);
endmodule

// File: rtl/exe_acc_unit.sv
module exe_acc_unit import exe_pkg::*; #(
  parameter int W  = 32,
  parameter int PW = 32,
  parameter int XN = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [3:0]             in_op,
  input  logic [W-1:0]           in_operand,
  input  logic [$clog2(XN)-1:0]  in_xreg,
  output logic [W-1:0]           acc_o,
  output logic [PW-1:0]          pc_o,
  output logic                   st_valid,
  output logic [W-1:0]           st_data,
  output logic                   xw_en,
  output logic [$clog2(XN)-1:0]  xw_sel,
  output logic [W-1:0]           xw_data,
  output logic                   halted,
  output logic                   done,
  output logic                   div_err
);
  localparam int XSW = $clog2(XN);

  op_e           op;
  logic          accept, is_md;
  logic [W-1:0]  acc_q, alu_res, md_res, st_d_q, xw_d_q;
  logic [PW-1:0] pc_q, br_next;
  logic          alu_wr, md_fin, md_dz;
  logic          halted_q, busy_q, done_q, st_v_q, xw_en_q, derr_q;
  logic [XSW-1:0] xw_sel_q;

  assign op       = op_e'(in_op);
  assign in_ready = !busy_q && !halted_q;
  assign accept   = in_valid && in_ready;
  assign is_md    = (op == OP_MUL) || (op == OP_DIV);

  exe_alu #(.W(W)) alu_i (
    .op(op), .acc(acc_q), .opnd(in_operand), .res(alu_res), .wr(alu_wr)
  );

  exe_branch #(.W(W), .PW(PW)) br_i (
    .op(op), .acc(acc_q), .pc(pc_q), .target(in_operand[PW-1:0]),
    .next_pc(br_next)
  );

  exe_muldiv #(.W(W)) md_i (
    .clk(clk), .rst_n(rst_n), .start(accept && is_md),
    .is_div(op == OP_DIV), .a(acc_q), .b(in_operand),
    .fin(md_fin), .dz(md_dz), .result(md_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0; pc_q <= '0; halted_q <= 1'b0; busy_q <= 1'b0;
      done_q <= 1'b0; st_v_q <= 1'b0; st_d_q <= '0;
      xw_en_q <= 1'b0; xw_sel_q <= '0; xw_d_q <= '0; derr_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      st_v_q  <= 1'b0;
      xw_en_q <= 1'b0;
      derr_q  <= 1'b0;
      if (accept) begin
        pc_q <= br_next;
        if (is_md) begin
          busy_q <= 1'b1;
        end else begin
          done_q <= 1'b1;
          if (alu_wr) acc_q <= alu_res;
          if (op == OP_HALT) halted_q <= 1'b1;
          if (op == OP_STA) begin
            st_v_q <= 1'b1;
            st_d_q <= acc_q;
          end
          if (op == OP_LDX) begin
            xw_en_q  <= 1'b1;
            xw_sel_q <= in_xreg;
            xw_d_q   <= in_operand;
          end
        end
      end
      if (md_fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        acc_q  <= md_res;
        derr_q <= md_dz;
      end
    end
  end

  assign acc_o    = acc_q;
  assign pc_o     = pc_q;
  assign st_valid = st_v_q;
  assign st_data  = st_d_q;
  assign xw_en    = xw_en_q;
  assign xw_sel   = xw_sel_q;
  assign xw_data  = xw_d_q;
  assign halted   = halted_q;
  assign done     = done_q;
  assign div_err  = derr_q;
endmodule

// File: rtl/exe_acc_unit_chk.sv
module exe_acc_unit_chk #(
  parameter int W  = 32,
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    in_op,
  input logic [W-1:0]  in_operand,
  input logic [W-1:0]  acc_o,
  input logic [PW-1:0] pc_o,
  input logic          halted,
  input logic          done,
  input logic          div_err
);
  logic acc_ev;
  assign acc_ev = in_valid && in_ready;

  a_r13_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r13_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !in_ready);
  a_r13_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(acc_o) && $stable(pc_o)));
  a_r11_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && in_op == 4'd11) |=> (pc_o == $past(in_operand[PW-1:0])));
  a_r3_negate: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && in_op == 4'd7) |=> (acc_o == -$past(acc_o)));
  a_r12_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && (in_op < 4'd10 || in_op > 4'd13)) |=> (pc_o == $past(pc_o) + PW'(1)));
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> done);
  a_r2_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && (in_op == 4'd5 || in_op == 4'd6)) |=> (!in_ready && !done));
endmodule

bind exe_acc_unit exe_acc_unit_chk #(.W(W), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_operand(in_operand), .acc_o(acc_o), .pc_o(pc_o),
  .halted(halted), .done(done), .div_err(div_err)
);

// File: tb/exe_acc_unit_tb_top.sv
module exe_acc_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = 4'd0;
  logic [31:0] in_operand = '0;
  logic [3:0]  in_xreg = 4'd0;
  logic [31:0] acc_o, pc_o, st_data, xw_data;
  logic        st_valid, xw_en, halted, done, div_err;
  logic [3:0]  xw_sel;

  int total = 0;
  int bad = 0;
  logic [31:0] racc = '0;
  logic [31:0] rpc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exe_acc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_operand(in_operand), .in_xreg(in_xreg),
    .acc_o(acc_o), .pc_o(pc_o), .st_valid(st_valid), .st_data(st_data),
    .xw_en(xw_en), .xw_sel(xw_sel), .xw_data(xw_data), .halted(halted),
    .done(done), .div_err(div_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0002;
      4: return 32'hFFFF_FFFE;
      5: return 32'h0000_0007;
      6: return 32'hFFFF_FFF9;
      7: return 32'h7FFF_FFFF;
      8: return 32'h8000_0000;
      default: return 32'h1234_5678;
    endcase
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [31:0] v,
                        input logic [3:0] xr, input string req);
    logic [31:0] e_acc, e_pc;
    logic e_err;
    longint q;
    int guard;
    e_acc = racc; e_pc = rpc + 32'd1; e_err = 1'b0;
    case (op)
      4'd0: e_acc = v;
      4'd3: e_acc = racc + v;
      4'd4: e_acc = racc - v;
      4'd5: e_acc = racc * v;
      4'd6: if (v == 0) e_err = 1'b1;
            else begin
              q = longint'($signed(racc)) / longint'($signed(v));
              e_acc = q[31:0];
            end
      4'd7: e_acc = -racc;
      4'd8: e_acc = racc << v[4:0];
      4'd9: e_acc = racc >> v[4:0];
      4'd10: if (racc[31]) e_pc = v;
      4'd11: e_pc = v;
      4'd12: if (racc == 0) e_pc = v;
      4'd13: e_pc = rpc;
      default: ;
    endcase
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_operand = v; in_xreg = xr;
    @(negedge clk);
    in_valid = 1'b0;
    if (op == 4'd5 || op == 4'd6)
      chk(!in_ready && !done, "R2 ready low while mul/div busy", {31'd0, in_ready}, 32'd0);
    guard = 0;
    while (!done && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk(done, "R2 done pulse", {31'd0, done}, 32'd1);
    chk(acc_o == e_acc, req, acc_o, e_acc);
    chk(pc_o == e_pc, "R12/R10/R11 program counter", pc_o, e_pc);
    if (op == 4'd6)
      chk(div_err == e_err, "R6 divide error flag", {31'd0, div_err}, {31'd0, e_err});
    if (op == 4'd1) begin
      chk(st_valid && st_data == racc, "R8 store data", st_data, racc);
    end
    if (op == 4'd2) begin
      chk(xw_en && xw_sel == xr && xw_data == v, "R9 index write", xw_data, v);
    end
    racc = e_acc; rpc = e_pc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(acc_o == 0 && pc_o == 0, "R1 reset acc/pc", acc_o, 32'd0);
    chk(in_ready && !halted && !done && !st_valid && !xw_en && !div_err,
        "R1 reset status", {27'd0, in_ready, halted, done, st_valid, xw_en}, 32'h10);

    // R3 R4 R5 R6 arithmetic sweep over corner pairs
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++) begin
        run_op(4'd0, corner(i), 4'd0, "R3 load");
        run_op(4'd3, corner(j), 4'd0, "R3 add");
        run_op(4'd0, corner(i), 4'd0, "R3 load");
        run_op(4'd4, corner(j), 4'd0, "R3 subtract");
        run_op(4'd0, corner(i), 4'd0, "R3 load");
        run_op(4'd5, corner(j), 4'd0, "R4 multiply");
        run_op(4'd0, corner(i), 4'd0, "R3 load");
        run_op(4'd6, corner(j), 4'd0, "R5 R6 divide");
        run_op(4'd7, 32'hDEAD_BEEF, 4'd0, "R3 negate");
      end

    // R7 shifts at every amount, upper operand bits set
    for (int s = 0; s < 32; s++) begin
      run_op(4'd0, 32'hF0C3_A5E1, 4'd0, "R3 load");
      run_op(4'd8, 32'hFFFF_FFE0 | s, 4'd0, "R7 shift left");
      run_op(4'd0, 32'h8F0C_3A5E, 4'd0, "R3 load");
      run_op(4'd9, 32'h0000_0AE0 | s, 4'd0, "R7 shift right");
    end

    // R10 R11 jumps on corner accumulators
    for (int i = 0; i < 10; i++) begin
      run_op(4'd0, corner(i), 4'd0, "R3 load");
      run_op(4'd10, 32'h0000_4000 + i, 4'd0, "R10 jump if negative");
      run_op(4'd12, 32'h0000_5000 + i, 4'd0, "R10 jump if zero");
      run_op(4'd11, 32'h0000_0100 * i, 4'd0, "R11 jump");
      run_op(4'd1, 32'h5555_5555, 4'd0, "R8 store keeps acc");
      run_op(4'd2, 32'hA000_0000 + i, 4'(i), "R9 index load keeps acc");
    end

    // random sequence against the model (no halt)
    for (int k = 0; k < 600; k++) begin
      logic [3:0] rop;
      rop = 4'($urandom_range(0, 15));
      if (rop == 4'd13) rop = 4'd14;
      run_op(rop, (k % 7 == 0) ? corner(k % 10) : $urandom, 4'($urandom_range(0, 15)),
             "R3 random sequence acc");
    end

    // R13 halt and freeze
    run_op(4'd0, 32'h0000_0042, 4'd0, "R3 load");
    run_op(4'd13, 32'h0000_9999, 4'd0, "R13 halt keeps acc");
    chk(halted && !in_ready, "R13 halted status", {30'd0, halted, in_ready}, 32'd2);
    in_valid = 1'b1; in_op = 4'd0; in_operand = 32'h1111_1111;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(acc_o == racc && pc_o == rpc && !done && halted, "R13 requests ignored",
          acc_o, racc);
    end
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc_o == 0 && pc_o == 0 && !halted && in_ready, "R1 reset after halt",
        acc_o, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule